// File: doc/BRIEF.md
# Reset-Time Memory Security Controller

This block settles, once per reset, whether the chip runs locked or open, and it shields the on-chip flash and EEPROM arrays from debug-port and scan-test access. While reset is held it captures the two security bits of the nonvolatile security byte and the special single-chip mode pin. Those captured values govern the whole session that follows. Changing the security byte later has no effect until the next reset.

When the field says locked and the chip starts in special single-chip mode, an internal sequencer reads every word of the combined flash and EEPROM address space through a simple read port. It checks that each word is fully erased. If all of them are erased, the session opens: the part is treated as unsecured and the debug port gets the full command set. If any word is not erased, the part stays locked with hardware-level commands only. Those commands can still reach the array control registers, so a mass erase can be started and the check repeated after the next reset.

Scan test blocks every array access at chip level, whatever the security state. A burn-in bypass input overrides security while it is asserted.

Top module: `nvm_sec_ctrl`

## Requirements
- R1: While `rst` is high the block captures `sec_field_i` and `special_i`. The field value 2'b10 is the only unlocked encoding; 2'b00, 2'b01 and 2'b11 all give a locked session (`secured_o`=1, `dbg_full_o`=0).
- R2: In a locked session started with `special_i`=0, no blank check runs: `bc_req_o` stays low, `bc_done_o` never pulses, and the part stays locked with hardware-only debug commands.
- R3: In a locked session started with `special_i`=1, the sequencer reads addresses 0,1,2,... in ascending order, one address per accepted transfer. A transfer is accepted in a cycle where `bc_req_o` and `bc_ack_i` are both high. While the request waits for an acknowledge, `bc_req_o` and `bc_addr_o` hold steady. Without stalls, the first read starts in the second cycle after reset is released.
- R4: An erased word reads all ones. At the first word that is not all ones, the sequencer stops and pulses `bc_done_o` for one cycle with `bc_pass_o`=0. The part then stays locked with hardware-only commands.
- R5: If all WORDS words read all ones, `bc_done_o` pulses once with `bc_pass_o`=1. One cycle later `secured_o` goes to 0 and `dbg_full_o` to 1, and both hold until the next reset.
- R6: While reset is held and while the blank check runs, `secured_o`=1 and `dbg_full_o`=0, unless the burn-in bypass is asserted.
- R7: Changing `sec_field_i` after reset is released leaves the session state unchanged. The new value takes effect only at the next reset.
- R8: While `scan_en_i`=1, `array_block_o`=1 and `dbg_rdata_o` is zero. While `scan_en_i`=0, `array_block_o`=0.
- R9: On a locked part, `dbg_rdata_o` reads zero. On an unlocked part outside scan test, `dbg_rdata_o` equals `dbg_rdata_i`.
- R10: While `burnin_byp_i`=1, `secured_o`=0 and `dbg_full_o`=1, even during reset. When it is released, the outputs return to the state decided for the session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the security inputs are captured while it is high |
| special_i | input | 1 | Mode pin: 1 selects special single-chip mode |
| sec_field_i | input | 2 | Security bits from the nonvolatile security byte |
| burnin_byp_i | input | 1 | Burn-in bypass; forces security off while high |
| scan_en_i | input | 1 | Scan test active |
| bc_req_o | output | 1 | Blank-check read request |
| bc_addr_o | output | AW | Blank-check read address |
| bc_ack_i | input | 1 | Array accepts the request; data valid in the same cycle |
| bc_rdata_i | input | DATA_W | Array read data |
| bc_done_o | output | 1 | One-cycle pulse when the blank check ends |
| bc_pass_o | output | 1 | Blank-check result, valid with the done pulse |
| dbg_rdata_i | input | DATA_W | Array read data headed to the debug port |
| dbg_rdata_o | output | DATA_W | Debug-port read data after security gating |
| secured_o | output | 1 | 1 while the part is secured |
| dbg_full_o | output | 1 | 1 = full debug command set, 0 = hardware commands only |
| array_block_o | output | 1 | Blocks all array accesses during scan test |

## Verification
On every cycle the assertions check the following:
- the read request and address hold steady while waiting for an acknowledge, and the address stays in range;
- the done pulse lasts a single cycle, and a non-erased word ends the sequence at once;
- a session decision, once made, stays fixed until reset;
- a normal-mode start never enters the check;
- the bypass always wins.

Only the bench scenarios can show the rest:
- the ascending address order;
- the exact cycle in which the result appears;
- that every locked field encoding in either mode leads to the right session;
- that a reprogrammed field only matters after a fresh reset;
- the gating of debug read data in each state.

// File: rtl/nvm_sec_pkg.sv
package nvm_sec_pkg;

    typedef enum logic [1:0] {
        SESS_EVAL   = 2'd0,
        SESS_CHECK  = 2'd1,
        SESS_LOCKED = 2'd2,
        SESS_OPEN   = 2'd3
    } sess_state_t;

    localparam logic [1:0] FIELD_UNLOCKED = 2'b10;

    typedef struct packed {
        logic done;
        logic pass;
    } bc_result_t;

    function automatic logic field_is_open(input logic [1:0] f);
        return f == FIELD_UNLOCKED;
    endfunction

endpackage

// File: rtl/sec_blank_check.sv
module sec_blank_check
    import nvm_sec_pkg::*;
#(
    parameter int WORDS  = 16,
    parameter int DATA_W = 8,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              req_o,
    output logic [AW-1:0]     addr_o,
    input  logic              ack_i,
    input  logic [DATA_W-1:0] rdata_i,
    output bc_result_t        res_o
);
    localparam logic [AW-1:0]     LAST_ADDR = AW'(WORDS - 1);
    localparam logic [DATA_W-1:0] ERASED    = '1;

    logic          busy_q;
    logic [AW-1:0] addr_q;
    bc_result_t    res_q;
    logic          word_bad;

    assign word_bad = rdata_i != ERASED;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            res_q  <= '0;
        end else begin
            res_q.done <= 1'b0;
            if (start_i && !busy_q) begin
                busy_q <= 1'b1;
                addr_q <= '0;
            end else if (busy_q && ack_i) begin
                if (word_bad) begin
                    busy_q     <= 1'b0;
                    res_q.done <= 1'b1;
                    res_q.pass <= 1'b0;
                end else if (addr_q == LAST_ADDR) begin
                    busy_q     <= 1'b0;
                    res_q.done <= 1'b1;
                    res_q.pass <= 1'b1;
                end else begin
                    addr_q <= addr_q + 1'b1;
                end
            end
        end
    end

    assign req_o  = busy_q;
    assign addr_o = addr_q;
    assign res_o  = res_q;

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (req_o && !ack_i) |=> (req_o && $stable(addr_o)));

    assert_addr_range_R3: assert property (@(posedge clk) disable iff (rst)
        req_o |-> (int'(addr_o) < WORDS));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        res_o.done |=> !res_o.done);

    assert_fail_stops_R4: assert property (@(posedge clk) disable iff (rst)
        (req_o && ack_i && word_bad) |=> (!req_o && res_o.done && !res_o.pass));

endmodule

// File: rtl/sec_session.sv
module sec_session
    import nvm_sec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  field_i,
    input  logic        special_i,
    input  bc_result_t  bc_res_i,
    output logic        start_o,
    output sess_state_t state_o
);
    logic [1:0]  field_q;
    logic        special_q;
    sess_state_t state_q;
    sess_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            field_q   <= field_i;
            special_q <= special_i;
        end
    end

    always_comb begin
        state_d = state_q;
        start_o = 1'b0;
        unique case (state_q)
            SESS_EVAL: begin
                if (field_is_open(field_q)) begin
                    state_d = SESS_OPEN;
                end else if (special_q) begin
                    state_d = SESS_CHECK;
                    start_o = 1'b1;
                end else begin
                    state_d = SESS_LOCKED;
                end
            end
            SESS_CHECK: begin
                if (bc_res_i.done) begin
                    state_d = bc_res_i.pass ? SESS_OPEN : SESS_LOCKED;
                end
            end
            SESS_LOCKED: state_d = SESS_LOCKED;
            SESS_OPEN:   state_d = SESS_OPEN;
            default:     state_d = SESS_EVAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SESS_EVAL;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

    assert_locked_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == SESS_LOCKED) |=> (state_q == SESS_LOCKED));

    assert_open_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == SESS_OPEN) |=> (state_q == SESS_OPEN));

    assert_normal_no_check_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == SESS_EVAL && !special_q) |=> (state_q != SESS_CHECK));

endmodule

// File: rtl/nvm_sec_ctrl.sv
module nvm_sec_ctrl
    import nvm_sec_pkg::*;
#(
    parameter int  WORDS  = 16,
    parameter int  DATA_W = 8,
    localparam int AW     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              special_i,
    input  logic [1:0]        sec_field_i,
    input  logic              burnin_byp_i,
    input  logic              scan_en_i,
    output logic              bc_req_o,
    output logic [AW-1:0]     bc_addr_o,
    input  logic              bc_ack_i,
    input  logic [DATA_W-1:0] bc_rdata_i,
    output logic              bc_done_o,
    output logic              bc_pass_o,
    input  logic [DATA_W-1:0] dbg_rdata_i,
    output logic [DATA_W-1:0] dbg_rdata_o,
    output logic              secured_o,
    output logic              dbg_full_o,
    output logic              array_block_o
);
    sess_state_t state;
    bc_result_t  bc_res;
    logic        bc_start;
    logic        sess_open;

    sec_session u_session (
        .clk       (clk),
        .rst       (rst),
        .field_i   (sec_field_i),
        .special_i (special_i),
        .bc_res_i  (bc_res),
        .start_o   (bc_start),
        .state_o   (state)
    );

    sec_blank_check #(
        .WORDS  (WORDS),
        .DATA_W (DATA_W),
        .AW     (AW)
    ) u_check (
        .clk     (clk),
        .rst     (rst),
        .start_i (bc_start),
        .req_o   (bc_req_o),
        .addr_o  (bc_addr_o),
        .ack_i   (bc_ack_i),
        .rdata_i (bc_rdata_i),
        .res_o   (bc_res)
    );

    assign sess_open     = (state == SESS_OPEN) && !rst;
    assign secured_o     = !burnin_byp_i && !sess_open;
    assign dbg_full_o    = burnin_byp_i || sess_open;
    assign array_block_o = scan_en_i;
    assign dbg_rdata_o   = (scan_en_i || secured_o) ? '0 : dbg_rdata_i;
    assign bc_done_o     = bc_res.done;
    assign bc_pass_o     = bc_res.pass;

    assert_bypass_wins_R10: assert property (@(posedge clk)
        burnin_byp_i |-> (!secured_o && dbg_full_o));

    assert_check_restrictive_R6: assert property (@(posedge clk) disable iff (rst)
        (bc_req_o && !burnin_byp_i) |-> (secured_o && !dbg_full_o));

    assert_scan_quiet_R8: assert property (@(posedge clk)
        scan_en_i |-> (array_block_o && dbg_rdata_o == '0));

endmodule

// File: tb/tb_nvm_sec_ctrl.sv
module tb_nvm_sec_ctrl;
    localparam int WORDS = 16;
    localparam int DW    = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          special = 1'b0;
    logic [1:0]    field = 2'b00;
    logic          byp = 1'b0;
    logic          scan = 1'b0;
    logic          bc_req, bc_ack, bc_done, bc_pass;
    logic [3:0]    bc_addr;
    logic [DW-1:0] bc_rdata, dbg_in, dbg_out;
    logic          secured, full, blk;
    logic          stall_en = 1'b0;
    logic          stall_ph = 1'b0;
    logic [DW-1:0] mem [WORDS];

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) stall_ph <= stall_en ? ~stall_ph : 1'b0;

    assign bc_ack   = bc_req && !stall_ph;
    assign bc_rdata = mem[bc_addr];

    nvm_sec_ctrl #(.WORDS(WORDS), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .special_i(special), .sec_field_i(field),
        .burnin_byp_i(byp), .scan_en_i(scan), .bc_req_o(bc_req),
        .bc_addr_o(bc_addr), .bc_ack_i(bc_ack), .bc_rdata_i(bc_rdata),
        .bc_done_o(bc_done), .bc_pass_o(bc_pass), .dbg_rdata_i(dbg_in),
        .dbg_rdata_o(dbg_out), .secured_o(secured), .dbg_full_o(full),
        .array_block_o(blk)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] f, input logic sp);
        @(negedge clk);
        rst = 1'b1; field = f; special = sp;
        repeat (2) @(negedge clk);
        if (!byp) chk("R6 reset restrictive", {secured, full}, 2'b10);
        rst = 1'b0;
    endtask

    task automatic run_case(input logic [1:0] f, input logic sp, input int fail_at, input logic st);
        int n = 0, done_n = -1, dones = 0, nxt = 0, pass_v = 0, restrict_bad = 0, order_bad = 0;
        bit do_check = (f != 2'b10) && sp;
        int last = (fail_at >= 0) ? fail_at : WORDS - 1;
        for (int i = 0; i < WORDS; i++) mem[i] = '1;
        if (fail_at >= 0) mem[fail_at] = 8'h3C;
        stall_en = st;
        do_reset(f, sp);
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            n++;
            if (do_check && done_n < 0 && (secured !== 1'b1 || full !== 1'b0)) restrict_bad++;
            if (bc_req && bc_ack) begin
                if (int'(bc_addr) != nxt) order_bad++;
                nxt++;
            end
            if (bc_done) begin
                dones++;
                if (done_n < 0) begin done_n = n; pass_v = bc_pass; end
            end
        end
        if (!do_check) begin
            chk("R2 no reads without check", nxt, 0);
            chk("R2 no done without check", dones, 0);
            chk("R1 session by field", {secured, full}, (f == 2'b10) ? 2'b01 : 2'b10);
        end else begin
            chk("R3 ascending addresses", order_bad, 0);
            chk("R3 read count", nxt, last + 1);
            chk("R4 single done pulse", dones, 1);
            chk("R4 R5 pass flag", pass_v, (fail_at < 0) ? 1 : 0);
            if (!st) chk("R3 R4 done cycle", done_n, last + 2);
            chk("R6 restrictive during check", restrict_bad, 0);
            chk("R4 R5 session after check", {secured, full}, (fail_at < 0) ? 2'b01 : 2'b10);
        end
        stall_en = 1'b0;
        field = ~f;
        repeat (3) @(negedge clk);
        chk("R7 field change ignored", {secured, full},
            (f == 2'b10 || (do_check && fail_at < 0)) ? 2'b01 : 2'b10);
    endtask

    initial begin
        automatic int fails[4] = '{-1, 0, 5, 15};
        dbg_in = 8'hA5;
        for (int i = 0; i < WORDS; i++) mem[i] = '1;
        @(negedge clk);
        chk("R6 restrictive in first reset", {secured, full}, 2'b10);
        for (int f = 0; f < 4; f++)
            for (int sp = 0; sp < 2; sp++)
                for (int k = 0; k < 4; k++)
                    for (int st = 0; st < 2; st++)
                        run_case(2'(f), 1'(sp), fails[k], 1'(st));

        // locked normal-mode session: gating, bypass, scan
        do_reset(2'b00, 1'b0);
        repeat (2) @(negedge clk);
        chk("R9 locked read is zero", int'(dbg_out), 0);
        chk("R8 no block without scan", int'(blk), 0);
        byp = 1'b1; #1;
        chk("R10 bypass opens", {secured, full}, 2'b01);
        chk("R10 bypass passes debug data", int'(dbg_out), 8'hA5);
        @(negedge clk); byp = 1'b0; #1;
        chk("R10 release returns to locked", {secured, full}, 2'b10);
        // reprogram field, then reset to open
        field = 2'b10;
        @(negedge clk);
        chk("R7 reprogram waits for reset", int'(secured), 1);
        do_reset(2'b10, 1'b0);
        @(negedge clk);
        chk("R7 R1 open after reset", {secured, full}, 2'b01);
        chk("R9 open passes debug data", int'(dbg_out), 8'hA5);
        scan = 1'b1; #1;
        chk("R8 scan blocks arrays", int'(blk), 1);
        chk("R8 scan zeroes debug data", int'(dbg_out), 0);
        scan = 1'b0;
        // bypass during reset
        byp = 1'b1;
        @(negedge clk); rst = 1'b1; field = 2'b00;
        @(negedge clk);
        chk("R10 bypass in reset", {secured, full}, 2'b01);
        byp = 1'b0; #1;
        chk("R6 reset restrictive after bypass", {secured, full}, 2'b10);
        rst = 1'b0;
        @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule